// File: doc/BRIEF.md
# Clocked Programmable Pulse Delay Line

This block delays a one-bit signal by a number of clock cycles chosen by a 5-bit selector. The delay is a fixed base latency plus the selector value times a per-step increment, so the 32 settings give strictly increasing delays. The selector is not captured. The output tap follows the selector pins at every cycle, so a change takes effect on bits that are already inside the line.

A force-low control drives the output to zero while it is high. A timing monitor sets a sticky hazard flag when the block is used in a way that could put a spurious pulse on the output. This happens in three cases. The input toggles during the settling window that follows an upward selector change. The selector changes again during that window. The output is re-enabled before the line has drained. A synchronous clear input resets the flag.

Data and control are plain level pins. There is no handshake: one input bit is taken on every clock cycle.

Top module: `pdl_delay_line`

## Requirements
- R1: With the selector held at value S, a one-cycle input pulse sampled on clock edge n appears on `sig_out` after edge n + BASE + S*STEP, where BASE=2 and STEP=1 by default. The output pulse is still one cycle wide.
- R2: Selector values 0, 7 and 31 give delays of 2, 9 and 33 cycles. Delay increases strictly with the selector value.
- R3: The selector is not captured. If the selector changes while a pulse is inside the line, the pulse leaves at the tap for the new value, measured from its original sampling edge.
- R4: While `force_low` is sampled high, `sig_out` is 0 one cycle later, whatever the input does.
- R5: An upward selector change from O to N starts a window of (N-O)*STEP cycles. An input toggle inside that window sets `hazard`.
- R6: A downward selector change starts no window. An input toggle right after it leaves `hazard` at 0.
- R7: A second selector change inside the window of an upward change sets `hazard`.
- R8: After `force_low` rises, the line needs S*STEP cycles of `force_low` high with the input low. Lowering `force_low` before that count has elapsed sets `hazard`.
- R9: Lowering `force_low` after the drain count has elapsed leaves `hazard` at 0.
- R10: `hazard` stays set until `err_clr` is sampled high, and then reads 0 one cycle later. When a clear and a new violation arrive in the same cycle, the clear wins.
- R11: A synchronous active-high `rst` clears the line, the counters and `hazard`, and holds `sig_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Signal to be delayed |
| dly_sel | input | SEL_W | Delay selector, used without capture |
| force_low | input | 1 | High forces the output to 0 |
| err_clr | input | 1 | Synchronous clear of the hazard flag |
| sig_out | output | 1 | Delayed signal, registered |
| hazard | output | 1 | Sticky timing-violation flag |

## Verification
A wrong tap index shows at `sig_out` as a pulse one or more cycles early or late, at the first pulse after the selector settles. A line that is not cleared shows as stray ones right after reset. A hold-off counter that loads the wrong value, or counts down at the wrong rate, shows on `hazard` within one cycle of the toggle or re-enable that lands at the window's edge. The directed tests place those events just inside and just outside each window.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // Number of shift stages needed to reach the farthest tap
  function automatic int unsigned line_depth(int unsigned base, int unsigned step,
                                             int unsigned sel_w);
    return base + ((32'd1 << sel_w) - 32'd1) * step;
  endfunction

  // Bits needed to hold values 0..v
  function automatic int unsigned span_bits(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction
endpackage

// File: rtl/pdl_tap_chain.sv
module pdl_tap_chain
  import pdl_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter int BASE  = 2,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DEPTH = int'(line_depth(BASE, STEP, SEL_W));

  logic [DEPTH-1:0] stage;
  logic [NSEL-1:0]  cand;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[DEPTH-2:0], din};
  end

  // One candidate per selector value; the output register adds the last cycle
  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign cand[g] = stage[BASE - 1 + g * STEP];
  end

  assign tap = cand[sel];
endmodule

// File: rtl/pdl_out_gate.sv
module pdl_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic force_low,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= tap & ~force_low;
  end
endmodule

// File: rtl/pdl_holdoff.sv
module pdl_holdoff
  import pdl_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             force_low,
  input  logic             err_clr,
  output logic             hazard
);
  localparam int MAXG  = ((1 << SEL_W) - 1) * STEP;
  localparam int CNT_W = int'(span_bits(MAXG));

  logic [SEL_W-1:0] prev_sel;
  logic             last_in;
  logic             off_q;
  logic [CNT_W-1:0] up_cnt;
  logic [CNT_W-1:0] drain_cnt;
  logic [CNT_W-1:0] up_load;
  logic [CNT_W-1:0] drain_load;
  logic             sel_chg, toggled, rise, fall, viol;

  assign sel_chg    = (sel != prev_sel);
  assign toggled    = din ^ last_in;
  assign rise       = force_low & ~off_q;
  assign fall       = ~force_low & off_q;
  assign up_load    = (sel > prev_sel) ? CNT_W'((32'(sel) - 32'(prev_sel)) * STEP) : '0;
  assign drain_load = CNT_W'(32'(sel) * STEP);
  assign viol       = ((up_cnt != '0) && (sel_chg || toggled)) ||
                      (fall && (drain_cnt != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sel  <= sel;
      last_in   <= din;
      off_q     <= force_low;
      up_cnt    <= '0;
      drain_cnt <= '0;
      hazard    <= 1'b0;
    end else begin
      last_in <= din;
      off_q   <= force_low;

      if (sel_chg) begin
        prev_sel <= sel;
        up_cnt   <= up_load;
      end else if (up_cnt != '0) begin
        up_cnt <= up_cnt - 1'b1;
      end

      if (!force_low)          drain_cnt <= '0;
      else if (rise || din)    drain_cnt <= drain_load;
      else if (drain_cnt != '0) drain_cnt <= drain_cnt - 1'b1;

      if (err_clr)   hazard <= 1'b0;
      else if (viol) hazard <= 1'b1;
    end
  end
endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line #(
  parameter int SEL_W = 5,
  parameter int BASE  = 2,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [SEL_W-1:0] dly_sel,
  input  logic             force_low,
  input  logic             err_clr,
  output logic             sig_out,
  output logic             hazard
);
  logic tap;

  pdl_tap_chain #(.SEL_W(SEL_W), .BASE(BASE), .STEP(STEP)) u_chain (
    .clk(clk), .rst(rst), .din(sig_in), .sel(dly_sel), .tap(tap)
  );

  pdl_out_gate u_gate (
    .clk(clk), .rst(rst), .tap(tap), .force_low(force_low), .q(sig_out)
  );

  pdl_holdoff #(.SEL_W(SEL_W), .STEP(STEP)) u_hold (
    .clk(clk), .rst(rst), .din(sig_in), .sel(dly_sel), .force_low(force_low),
    .err_clr(err_clr), .hazard(hazard)
  );
endmodule

// File: rtl/pdl_delay_line_chk.sv
module pdl_delay_line_chk #(
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             sig_in,
  input logic [SEL_W-1:0] dly_sel,
  input logic             force_low,
  input logic             err_clr,
  input logic             sig_out,
  input logic             hazard
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sig_out && !hazard)); // R11

  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    force_low |=> !sig_out); // R4

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (hazard && !err_clr) |=> hazard); // R10

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> !hazard); // R10

  AST_DOUBLE_SEL: assert property (@(posedge clk) disable iff (rst)
    ((dly_sel > $past(dly_sel)) ##1 ((dly_sel != $past(dly_sel)) && !err_clr))
    |=> hazard); // R7

  AST_EARLY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((force_low && !$past(force_low) && (dly_sel != '0)) ##1 (!force_low && !err_clr))
    |=> hazard); // R8

  AST_INPUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({sig_in, sig_out})); // R1
endmodule

bind pdl_delay_line pdl_delay_line_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .sig_in(sig_in), .dly_sel(dly_sel), .force_low(force_low),
  .err_clr(err_clr), .sig_out(sig_out), .hazard(hazard)
);

// File: tb/tb_pdl_delay_line.sv
module tb_pdl_delay_line;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;
  localparam int STEP = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sig_in = 1'b0;
  logic [4:0] dly_sel = '0;
  logic       force_low = 1'b0;
  logic       err_clr = 1'b0;
  logic       sig_out, hazard;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pdl_delay_line dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .dly_sel(dly_sel), .force_low(force_low),
    .err_clr(err_clr), .sig_out(sig_out), .hazard(hazard)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
  endtask

  // Send a one-cycle pulse and return latency in edges and output pulse width
  task automatic send_pulse(output int lat, output int width);
    lat = -1; width = 0;
    sig_in = 1'b1; tick(1);
    sig_in = 1'b0;
    for (int k = 1; k < 60; k++) begin
      if (sig_out) begin
        if (lat < 0) lat = k - 1;
        width++;
      end
      tick(1);
    end
  endtask

  task automatic t_reset();
    check(sig_out == 1'b0, "R11", int'(sig_out), 0);
    check(hazard == 1'b0, "R11", int'(hazard), 0);
  endtask

  task automatic t_latency(input logic [4:0] s, input string req, output int lat);
    int w;
    dly_sel = s; tick(40);
    send_pulse(lat, w);
    check(lat == BASE + int'(s) * STEP, req, lat, BASE + int'(s) * STEP);
    check(w == 1, req, w, 1);
    check(hazard == 1'b0, req, int'(hazard), 0);
  endtask

  task automatic t_follow();  // R3
    int lat;
    dly_sel = 5'd20; tick(40);
    lat = -1;
    sig_in = 1'b1; tick(1);
    sig_in = 1'b0; tick(1);
    dly_sel = 5'd4;
    for (int k = 2; k < 60; k++) begin
      if (sig_out && lat < 0) lat = k - 1;
      tick(1);
    end
    check(lat == BASE + 4 * STEP, "R3", lat, BASE + 4 * STEP);
    check(hazard == 1'b0, "R3", int'(hazard), 0);
  endtask

  task automatic t_force_low();  // R4, R9
    int bad = 0;
    dly_sel = 5'd3; tick(10);
    force_low = 1'b1; tick(1);
    for (int k = 0; k < 12; k++) begin
      sig_in = ~sig_in;
      tick(1);
      if (sig_out) bad++;
    end
    sig_in = 1'b0;
    tick(3 * STEP + 3);
    check(bad == 0, "R4", bad, 0);
    force_low = 1'b0; tick(2);
    check(hazard == 1'b0, "R9", int'(hazard), 0);
  endtask

  task automatic t_early_enable();  // R8, R10
    dly_sel = 5'd7; tick(12);
    force_low = 1'b1; tick(1);
    sig_in = 1'b1; tick(1);
    sig_in = 1'b0; tick(2);
    force_low = 1'b0; tick(2);
    check(hazard == 1'b1, "R8", int'(hazard), 1);
    tick(8);
    check(hazard == 1'b1, "R10", int'(hazard), 1);
    clear_flag();
    check(hazard == 1'b0, "R10", int'(hazard), 0);
  endtask

  task automatic t_up_guard();  // R5
    dly_sel = 5'd20; tick(3);
    sig_in = 1'b1; tick(1);
    sig_in = 1'b0; tick(1);
    check(hazard == 1'b1, "R5", int'(hazard), 1);
    tick(20); clear_flag();
  endtask

  task automatic t_down_guard();  // R6
    dly_sel = 5'd4; tick(1);
    sig_in = 1'b1; tick(1);
    sig_in = 1'b0; tick(2);
    check(hazard == 1'b0, "R6", int'(hazard), 0);
  endtask

  task automatic t_double();  // R7
    dly_sel = 5'd9; tick(1);
    dly_sel = 5'd12; tick(1);
    check(hazard == 1'b1, "R7", int'(hazard), 1);
    tick(20); clear_flag();
  endtask

  task automatic t_clear_wins();  // R10
    dly_sel = 5'd14; tick(1);
    dly_sel = 5'd15; err_clr = 1'b1; tick(1);
    err_clr = 1'b0;
    check(hazard == 1'b0, "R10", int'(hazard), 0);
    tick(5);
  endtask

  initial begin
    int l0, l7, l31;
    tick(3);
    t_reset();
    rst = 1'b0; tick(2);
    t_latency(5'd0, "R1", l0);
    t_latency(5'd7, "R1", l7);
    t_latency(5'd31, "R2", l31);
    check((l31 > l7) && (l7 > l0), "R2", l31 - l7, 24);
    t_follow();
    t_force_low();
    t_early_enable();
    dly_sel = 5'd7; tick(30);
    t_up_guard();
    t_down_guard();
    t_double();
    t_clear_wins();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule